// File: doc/BRIEF.md
# Bidirectional Logical Shifter

A combinational logical shift unit for a 32-bit DSP datapath. A single signed count decides both the direction and the distance of the shift. A positive count moves bits toward the most significant end. A negative count moves them toward the least significant end, and zeros fill the vacated positions in both directions. Bits pushed past either end of a lane are lost, and there is no saturation.

The same unit serves four lane arrangements, chosen by a 2-bit mode:

- one 16-bit half-word, taken from the high or low half of the source;
- two independent 16-bit halves shifted by the same count;
- one 32-bit word;
- one 40-bit accumulator value.

Next to the result, the unit gives a two-bit write enable. A register file uses it to update only the addressed half of a destination when the operation works on a single half-word.

Top module: `bidir_lshift`

## Requirements
- R1: The count is the signed two's-complement value of `cnt_i[5:0]`, from -32 to +31. Positive values shift left and negative values shift right by the magnitude. Bits `cnt_i[15:6]` have no effect on any output.
- R2: Right shifts are logical and fill with zeros whatever the top bit of the data. In half-word mode, 0x80f0 shifted by -1 gives 0x4078. In vector mode, 0x80f080f0 shifted by -2 gives 0x203c203c.
- R3: Left shifts drop the bits that leave the top of the lane, without saturation. In full-word mode, 0xf80fe00f shifted by +4 gives 0x80fe00f0.
- R4: Mode 2'b00 (half) shifts `src_i[31:16]` when `hi_sel_i` is 1 and `src_i[15:0]` when it is 0. The result appears at the same bit position in `res_o`, and every other bit of `res_o` is 0. `wr_en_o` is 2'b10 for the high half and 2'b01 for the low half.
- R5: Mode 2'b01 (vector) shifts `src_i[31:16]` and `src_i[15:0]` separately by the same count, and no bit crosses bit 16. `wr_en_o` is 2'b11.
- R6: Mode 2'b10 (word) shifts `src_i[31:0]` as one 32-bit value, so bits cross between the halves. In this mode, 0x80f080f0 shifted by -3 gives 0x101e101e. `res_o[39:32]` is 0 in every mode except 2'b11. `wr_en_o` is 2'b11.
- R7: Mode 2'b11 (accumulator) shifts all 40 bits of `src_i` as one value. `wr_en_o` is 2'b11.
- R8: When the count magnitude is at least the lane width, the lane result is all zeros. The lane width is 16 for half and vector mode and 32 for word mode.
- R9: A count of zero passes the selected lane or lanes through unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 40 | Source operand. Bits 31:0 hold the word and bits 39:0 hold the accumulator |
| cnt_i | input | 16 | Count field. The low 6 bits are read as a signed shift count |
| mode_i | input | 2 | Lane arrangement: 00 half, 01 vector, 10 word, 11 accumulator |
| hi_sel_i | input | 1 | In half mode, selects the high (1) or low (0) half |
| res_o | output | 40 | Shifted result |
| wr_en_o | output | 2 | Per-half write enable. Bit 1 is the high half and bit 0 is the low half |

## Verification
The unit has no state, so any fault in count decoding, lane selection or the range check shows at the ports in the same cycle the inputs are applied. A misread sign bit shifts the data the wrong way. A missing magnitude check leaves stale bits where zeros belong. A leak across the half boundary in vector mode sets bit 15 or bit 16 of the result. Random operands with random upper count bits are mixed with the boundary counts 0, ±16, +31 and -32 in each mode. This catches a wrong decode or lane choice on the first vector that exercises it.

// File: rtl/bls_pkg.sv
package bls_pkg;

   typedef enum logic [1:0] {
      MODE_HALF = 2'b00,
      MODE_VEC  = 2'b01,
      MODE_WORD = 2'b10,
      MODE_ACC  = 2'b11
   } shift_mode_e;

endpackage

// File: rtl/bls_count_decode.sv
module bls_count_decode #(
   parameter int FIELD_W = 16,
   parameter int CNT_W   = 6
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic               left_o,
   output logic [CNT_W-1:0]   mag_o
);

   logic [CNT_W-1:0] cnt_raw;

   assign cnt_raw = field_i[CNT_W-1:0];
   assign left_o  = ~cnt_raw[CNT_W-1];
   // negation of the most negative value wraps back to the magnitude itself
   assign mag_o   = cnt_raw[CNT_W-1] ? (~cnt_raw + 1'b1) : cnt_raw;

endmodule

// File: rtl/bls_shift_lane.sv
module bls_shift_lane #(
   parameter int W     = 16,
   parameter int MAG_W = 6
) (
   input  logic [W-1:0]     d_i,
   input  logic             left_i,
   input  logic [MAG_W-1:0] mag_i,
   output logic [W-1:0]     q_o
);

   localparam int MAX_MAG = 2 ** (MAG_W - 1);

   logic [W-1:0] shifted;

   assign shifted = left_i ? (d_i << mag_i) : (d_i >> mag_i);

   generate
      if (W > MAX_MAG) begin : g_no_range
         // no count can reach the lane width: plain barrel shift
         assign q_o = shifted;
      end else begin : g_range
         localparam logic [MAG_W-1:0] W_L = MAG_W'(W);
         assign q_o = (mag_i >= W_L) ? '0 : shifted;
      end
   endgenerate

endmodule

// File: rtl/bidir_lshift.sv
module bidir_lshift
   import bls_pkg::*;
#(
   parameter int HALF_W  = 16,
   parameter int ACC_W   = 40,
   parameter int FIELD_W = 16,
   parameter int CNT_W   = 6
) (
   input  logic [ACC_W-1:0]   src_i,
   input  logic [FIELD_W-1:0] cnt_i,
   input  logic [1:0]         mode_i,
   input  logic               hi_sel_i,
   output logic [ACC_W-1:0]   res_o,
   output logic [1:0]         wr_en_o
);

   localparam int WORD_W = 2 * HALF_W;
   localparam int NLANE  = 2;

   if (ACC_W <= WORD_W) begin : g_bad_acc
      $error("ACC_W must exceed twice HALF_W");
   end
   if (CNT_W > FIELD_W || CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be between 2 and FIELD_W");
   end

   logic             left;
   logic [CNT_W-1:0] mag;

   bls_count_decode #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_cnt (
      .field_i (cnt_i),
      .left_o  (left),
      .mag_o   (mag)
   );

   // single half lane
   logic [HALF_W-1:0] half_src, half_q;
   assign half_src = hi_sel_i ? src_i[WORD_W-1:HALF_W] : src_i[HALF_W-1:0];

   bls_shift_lane #(.W(HALF_W), .MAG_W(CNT_W)) u_half (
      .d_i    (half_src),
      .left_i (left),
      .mag_i  (mag),
      .q_o    (half_q)
   );

   // vector lanes
   logic [WORD_W-1:0] vec_q;
   for (genvar g = 0; g < NLANE; g++) begin : g_vec
      bls_shift_lane #(.W(HALF_W), .MAG_W(CNT_W)) u_lane (
         .d_i    (src_i[g*HALF_W +: HALF_W]),
         .left_i (left),
         .mag_i  (mag),
         .q_o    (vec_q[g*HALF_W +: HALF_W])
      );
   end

   // full word lane
   logic [WORD_W-1:0] word_q;
   bls_shift_lane #(.W(WORD_W), .MAG_W(CNT_W)) u_word (
      .d_i    (src_i[WORD_W-1:0]),
      .left_i (left),
      .mag_i  (mag),
      .q_o    (word_q)
   );

   // accumulator lane
   logic [ACC_W-1:0] acc_q;
   bls_shift_lane #(.W(ACC_W), .MAG_W(CNT_W)) u_acc (
      .d_i    (src_i),
      .left_i (left),
      .mag_i  (mag),
      .q_o    (acc_q)
   );

   shift_mode_e mode;
   assign mode = shift_mode_e'(mode_i);

   always_comb begin
      res_o   = '0;
      wr_en_o = 2'b11;
      unique case (mode)
         MODE_HALF: begin
            if (hi_sel_i) begin
               res_o[WORD_W-1:HALF_W] = half_q;
               wr_en_o                = 2'b10;
            end else begin
               res_o[HALF_W-1:0] = half_q;
               wr_en_o           = 2'b01;
            end
         end
         MODE_VEC:  res_o[WORD_W-1:0] = vec_q;
         MODE_WORD: res_o[WORD_W-1:0] = word_q;
         MODE_ACC:  res_o             = acc_q;
         default:   res_o             = '0;
      endcase
   end

endmodule

// File: rtl/bidir_lshift_chk.sv
module bidir_lshift_chk #(
   parameter int HALF_W  = 16,
   parameter int ACC_W   = 40,
   parameter int FIELD_W = 16,
   parameter int CNT_W   = 6
) (
   input logic [ACC_W-1:0]   src_i,
   input logic [FIELD_W-1:0] cnt_i,
   input logic [1:0]         mode_i,
   input logic               hi_sel_i,
   input logic [ACC_W-1:0]   res_o,
   input logic [1:0]         wr_en_o
);

   localparam int WORD_W = 2 * HALF_W;

   logic [CNT_W-1:0] c6;
   logic             neg, known;

   assign c6    = cnt_i[CNT_W-1:0];
   assign neg   = c6[CNT_W-1];
   assign known = !$isunknown({src_i, cnt_i, mode_i, hi_sel_i});

   always_comb begin
      if (known) begin
         // R4: half mode writes exactly the addressed half
         if (mode_i == 2'b00) begin
            a_r4_half_wren: assert ($onehot(wr_en_o) && (wr_en_o[1] == hi_sel_i));
            a_r4_other_zero: assert (hi_sel_i ? (res_o[HALF_W-1:0] == '0)
                                              : (res_o[WORD_W-1:HALF_W] == '0));
         end
         // R5 R6 R7: whole-register modes enable both halves
         if (mode_i != 2'b00) begin
            a_r5_wren_both: assert (wr_en_o == 2'b11);
         end
         // R6: accumulator extension is clear outside accumulator mode
         if (mode_i != 2'b11) begin
            a_r6_upper_clear: assert (res_o[ACC_W-1:WORD_W] == '0);
         end
         // R2: a right shift of the word clears its top bit
         if (mode_i == 2'b10 && neg) begin
            a_r2_zero_fill: assert (res_o[WORD_W-1] == 1'b0);
         end
         // R5: nothing crosses the half boundary in vector mode
         if (mode_i == 2'b01 && c6 != '0) begin
            a_r5_no_cross: assert (neg ? (res_o[HALF_W-1] == 1'b0)
                                       : (res_o[HALF_W] == 1'b0));
         end
         // R8: left counts at or beyond the half width clear vector lanes
         if (mode_i == 2'b01 && !neg && c6 >= CNT_W'(HALF_W)) begin
            a_r8_range: assert (res_o[WORD_W-1:0] == '0);
         end
         // R9: zero count passes the word and the accumulator through
         if (c6 == '0 && mode_i == 2'b10) begin
            a_r9_zero_word: assert (res_o[WORD_W-1:0] == src_i[WORD_W-1:0]);
         end
         if (c6 == '0 && mode_i == 2'b11) begin
            a_r9_zero_acc: assert (res_o == src_i);
         end
      end
   end

endmodule

bind bidir_lshift bidir_lshift_chk #(
   .HALF_W(HALF_W), .ACC_W(ACC_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)
) u_chk (
   .src_i(src_i), .cnt_i(cnt_i), .mode_i(mode_i), .hi_sel_i(hi_sel_i),
   .res_o(res_o), .wr_en_o(wr_en_o)
);

// File: tb/bidir_lshift_test.sv
module bidir_lshift_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [39:0] src;
   logic [15:0] cnt;
   logic [1:0]  mode;
   logic        hi;
   logic [39:0] res;
   logic [1:0]  wen;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   bidir_lshift uut (
      .src_i(src), .cnt_i(cnt), .mode_i(mode), .hi_sel_i(hi),
      .res_o(res), .wr_en_o(wen)
   );

   function automatic longint unsigned lane_ref(longint unsigned v, int w, int c);
      longint unsigned m = (64'd1 << w) - 64'd1;
      if (c >= w || -c >= w) return 64'd0;
      if (c >= 0) return (v << c) & m;
      return (v & m) >> (-c);
   endfunction

   function automatic logic [39:0] res_ref(logic [39:0] s, logic [15:0] k, logic [1:0] md, logic h);
      int c = int'($signed(k[5:0]));
      logic [39:0] r = '0;
      case (md)
         2'b00: if (h) r[31:16] = 16'(lane_ref(64'(s[31:16]), 16, c));
                else   r[15:0]  = 16'(lane_ref(64'(s[15:0]), 16, c));
         2'b01: begin
            r[31:16] = 16'(lane_ref(64'(s[31:16]), 16, c));
            r[15:0]  = 16'(lane_ref(64'(s[15:0]), 16, c));
         end
         2'b10: r[31:0] = 32'(lane_ref(64'(s[31:0]), 32, c));
         default: r = 40'(lane_ref(64'(s), 40, c));
      endcase
      return r;
   endfunction

   function automatic logic [1:0] wen_ref(logic [1:0] md, logic h);
      if (md != 2'b00) return 2'b11;
      return h ? 2'b10 : 2'b01;
   endfunction

   task automatic apply(input logic [39:0] s, input logic [15:0] k,
                        input logic [1:0] md, input logic h);
      @(posedge clk);
      src = s; cnt = k; mode = md; hi = h;
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [39:0] exp_r, input logic [1:0] exp_w);
      n_run++;
      if (res !== exp_r || wen !== exp_w) begin
         n_fail++;
         $display("FAIL %s: src=%h cnt=%h mode=%b hi=%b res=%h wen=%b expected res=%h wen=%b",
                  tag, src, cnt, mode, hi, res, wen, exp_r, exp_w);
      end
   endtask

   task automatic run(input string tag, input logic [39:0] s, input logic [15:0] k,
                      input logic [1:0] md, input logic h);
      apply(s, k, md, h);
      check(tag, res_ref(s, k, md, h), wen_ref(md, h));
   endtask

   initial begin
      #2000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      src = '0; cnt = '0; mode = 2'b00; hi = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R4 idle state", 40'h0, 2'b01);

      // R2 zero fill, half and vector
      apply(40'h0000_0080f0, 16'hffff, 2'b00, 1'b0);
      check("R2 half low -1", 40'h00_0000_4078, 2'b01);
      apply(40'h00_80f0_80f0, 16'hfffe, 2'b01, 1'b0);
      check("R2 vector -2", 40'h00_203c_203c, 2'b11);
      // R6 word crossing
      apply(40'h00_80f0_80f0, 16'h003d, 2'b10, 1'b0);
      check("R6 word -3", 40'h00_101e_101e, 2'b11);
      // R3 no saturation
      apply(40'h00_f80f_e00f, 16'h0004, 2'b10, 1'b0);
      check("R3 word +4", 40'h00_80fe_00f0, 2'b11);
      // R4 high half
      apply(40'hff_0001_0001, 16'h0001, 2'b00, 1'b1);
      check("R4 half high +1", 40'h00_0002_0000, 2'b10);
      // R5 vector left, no carry between halves
      apply(40'h00_8001_8001, 16'h0001, 2'b01, 1'b0);
      check("R5 vector +1", 40'h00_0002_0002, 2'b11);
      // R7 accumulator
      apply(40'hab_0000_0001, 16'h001f, 2'b11, 1'b0);
      check("R7 acc +31", 40'h00_8000_0000, 2'b11);
      apply(40'hff_1234_5678, 16'h0020, 2'b11, 1'b0);
      check("R7 acc -32", 40'h00_0000_00ff, 2'b11);
      // R8 range limits
      apply(40'h00_ffff_ffff, 16'h0010, 2'b01, 1'b0);
      check("R8 vector +16", 40'h0, 2'b11);
      apply(40'h00_ffff_ffff, 16'h0020, 2'b10, 1'b0);
      check("R8 word -32", 40'h0, 2'b11);
      apply(40'h00_ffff_ffff, 16'h0030, 2'b00, 1'b1);
      check("R8 half -16", 40'h0, 2'b10);
      // R9 zero count (R1 upper bits ignored)
      apply(40'h5a_dead_beef, 16'hffc0, 2'b10, 1'b0);
      check("R9 R1 word zero", 40'h00_dead_beef, 2'b11);
      apply(40'h5a_dead_beef, 16'h0000, 2'b11, 1'b0);
      check("R9 acc zero", 40'h5a_dead_beef, 2'b11);
      apply(40'h5a_dead_beef, 16'h0000, 2'b00, 1'b1);
      check("R9 half zero", 40'h00_dead_0000, 2'b10);
      // R1 upper count bits ignored
      apply(40'h00_0000_0001, 16'hab05, 2'b10, 1'b0);
      check("R1 upper bits", 40'h00_0000_0020, 2'b11);

      // random with fixed seed
      void'($urandom(32'd20240611));
      for (int i = 0; i < 600; i++) begin
         logic [39:0] s;
         logic [15:0] k;
         s = {8'($urandom), 32'($urandom)};
         k = 16'($urandom);
         if (i % 4 == 0) k[5:0] = 6'($urandom_range(0, 3)) ? 6'd0 : 6'h20;
         run("R1 random", s, k, 2'($urandom), 1'($urandom));
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule